// File: doc/BRIEF.md
# Boot-Remapping System Address Decoder

This block turns the 16-bit address of an 8-bit processor into one-hot chip selects for the memories and peripherals on a small board. Five kinds of target are decoded. Program RAM sits at the bottom of the map. Up to eight parallel-port adapters share a reserved window, with one 4-byte adapter in each 1 KB step. A combined timer/IO device is decoded only partly, so address bits 10 and 11 are don't-care. The monitor ROM fills the top 1 KB of the lower half of the map. A small interrupt-vector RAM sits at the very top of the map.

The processor reads its start vector from the top of the map, and that vector RAM is volatile. To make boot work, the block clears bit 15 of the effective address while the processor is held in reset. The vector read is therefore served from the matching locations in the monitor ROM. The reset input is asserted asynchronously and released through a short synchronizer. The override ends on the same clock edge that releases the synchronized reset. The effective address is also driven out so that the devices see the same bit 15 as the decoder.

Top module: `sysdec_top`

## Requirements
- R1: `ram_sel` is high exactly for effective addresses 0x0000 to 0x01FF.
- R2: `rom_sel` is high exactly for effective addresses 0x7C00 to 0x7FFF.
- R3: `vec_sel` is high exactly for effective addresses 0xFFC0 to 0xFFFF, so it is never high while the reset override is active.
- R4: For adapter slot k (0 to PIA_SLOTS-1), `pia_sel[k]` (bit k) is high exactly for 0x4000+k*0x400 to 0x4003+k*0x400. The address 4 above each slot's base selects nothing.
- R5: `iot_sel` is high for 0x6200 to 0x6207 and for each alias formed by giving address bits 11:10 any value (0x6600, 0x6A00 and 0x6E00 bases). Addresses 0x61FF and 0x6208 select nothing.
- R6: While `rst_n` is low, and until the override is released, `eff_addr` equals `cpu_addr` with bit 15 cleared, and the selects decode that value. A read of 0xFFFC or 0xFFFD therefore yields `eff_addr` 0x7FFC or 0x7FFD with `rom_sel` high. A fall of `rst_n` applies the override at once, with no clock edge needed.
- R7: After `rst_n` rises, the override stays on through the first rising clock edge and is released on rising edge number SYNC_STAGES (default 2). From then on `eff_addr` equals `cpu_addr`, and 0xFFFC gives `vec_sel`.
- R8: At most one select is high for any address. Unmapped addresses (for example 0x0200, 0x3FFF, 0x8000, 0xFFBF) select nothing.
- R9: `eff_addr` and all selects follow `cpu_addr` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reset synchronizer |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cpu_addr | input | 16 | Processor address bus |
| eff_addr | output | 16 | Effective address driven to the devices (bit 15 cleared during the override) |
| ram_sel | output | 1 | Program RAM select |
| pia_sel | output | PIA_SLOTS | Parallel adapter selects, one bit per slot |
| iot_sel | output | 1 | Timer/IO device select |
| rom_sel | output | 1 | Monitor ROM select |
| vec_sel | output | 1 | Interrupt-vector RAM select |

## Verification
The address path is purely combinational. The bench therefore changes `cpu_addr` at a falling edge and samples a couple of nanoseconds later in the same cycle, without waiting for any edge. The override is applied without a clock when `rst_n` falls, so that check also samples shortly after the drive. Release depends on counting edges. The bench raises `rst_n` at a falling edge and samples at the following falling edges: the override must still hold after the first rising edge and must be gone after the second. Expected selects come from a bench model written with plain range comparisons.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;
  localparam int ADDR_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;

  // care mask: 1 = bit takes part in the compare
  localparam addr_t RAM_BASE = 16'h0000, RAM_CARE = 16'hFE00;
  localparam addr_t ROM_BASE = 16'h7C00, ROM_CARE = 16'hFC00;
  localparam addr_t VEC_BASE = 16'hFFC0, VEC_CARE = 16'hFFC0;
  localparam addr_t IOT_BASE = 16'h6200, IOT_CARE = 16'hF3F8;
  localparam addr_t PIA_BASE = 16'h4000, PIA_CARE = 16'hFFFC;
  localparam addr_t PIA_STEP = 16'h0400;

  function automatic logic region_hit(addr_t a, addr_t base, addr_t care);
    return ((a ^ base) & care) == '0;
  endfunction

  function automatic addr_t pia_slot_base(int k);
    return PIA_BASE + addr_t'(k) * PIA_STEP;
  endfunction

  function automatic addr_t boot_fix(addr_t a, logic hold);
    return hold ? {1'b0, a[ADDR_W-2:0]} : a;
  endfunction
endpackage

// File: rtl/sysdec_rst_sync.sv
module sysdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign hold = ~chain[STAGES-1];
endmodule

// File: rtl/sysdec_addr_fix.sv
module sysdec_addr_fix
  import sysdec_pkg::*;
(
  input  addr_t raw,
  input  logic  hold,
  output addr_t eff
);
  assign eff = boot_fix(raw, hold);
endmodule

// File: rtl/sysdec_match.sv
module sysdec_match
  import sysdec_pkg::*;
#(
  parameter addr_t BASE = '0,
  parameter addr_t CARE = '1
) (
  input  addr_t addr,
  output logic  hit
);
  assign hit = region_hit(addr, BASE, CARE);
endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
  import sysdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIA_SLOTS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  output logic [15:0]          eff_addr,
  output logic                 ram_sel,
  output logic [PIA_SLOTS-1:0] pia_sel,
  output logic                 iot_sel,
  output logic                 rom_sel,
  output logic                 vec_sel
);
  logic boot_hold;

  sysdec_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(boot_hold));

  sysdec_addr_fix u_fix (.raw(cpu_addr), .hold(boot_hold), .eff(eff_addr));

  sysdec_match #(.BASE(RAM_BASE), .CARE(RAM_CARE)) u_ram (.addr(eff_addr), .hit(ram_sel));
  sysdec_match #(.BASE(ROM_BASE), .CARE(ROM_CARE)) u_rom (.addr(eff_addr), .hit(rom_sel));
  sysdec_match #(.BASE(VEC_BASE), .CARE(VEC_CARE)) u_vec (.addr(eff_addr), .hit(vec_sel));
  sysdec_match #(.BASE(IOT_BASE), .CARE(IOT_CARE)) u_iot (.addr(eff_addr), .hit(iot_sel));

  for (genvar k = 0; k < PIA_SLOTS; k++) begin : g_pia
    sysdec_match #(.BASE(pia_slot_base(k)), .CARE(PIA_CARE)) u_pia (
      .addr(eff_addr), .hit(pia_sel[k]));
  end
endmodule

// File: rtl/sysdec_chk.sv
module sysdec_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int PIA_SLOTS   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          cpu_addr,
  input logic [15:0]          eff_addr,
  input logic                 ram_sel,
  input logic [PIA_SLOTS-1:0] pia_sel,
  input logic                 iot_sel,
  input logic                 rom_sel,
  input logic                 vec_sel
);
  localparam int CW = $clog2(SYNC_STAGES + 1);
  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt < CW'(SYNC_STAGES)) up_cnt <= up_cnt + 1'b1;
  end

  // R7: released once SYNC_STAGES edges have seen rst_n high
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == CW'(SYNC_STAGES)) |-> (eff_addr == cpu_addr));

  // R8: one-hot-or-none selects
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, pia_sel, iot_sel, rom_sel, vec_sel}));

  // R5: timer/IO hits only inside its 8-byte window modulo bits 11:10
  a_r5_iot_window: assert property (@(posedge clk) disable iff (!rst_n)
    iot_sel |-> (cpu_addr[9:3] == 7'b1000000 && cpu_addr[14:12] == 3'b110));

  always @(negedge clk) begin
    if (rst_n === 1'b0 && !$isunknown(cpu_addr)) begin
      a_r6_bit15_low: assert (eff_addr == {1'b0, cpu_addr[14:0]});
      a_r3_no_vec_in_reset: assert (!vec_sel);
      if (cpu_addr == 16'hFFFC) a_r6_vector_rom: assert (rom_sel);
    end
  end
endmodule

bind sysdec_top sysdec_chk #(.SYNC_STAGES(SYNC_STAGES), .PIA_SLOTS(PIA_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .eff_addr(eff_addr),
  .ram_sel(ram_sel), .pia_sel(pia_sel), .iot_sel(iot_sel),
  .rom_sel(rom_sel), .vec_sel(vec_sel));

// File: tb/sysdec_top_tb.sv
module sysdec_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [15:0] eff_addr;
  logic        ram_sel, iot_sel, rom_sel, vec_sel;
  logic [7:0]  pia_sel;
  int n_tests = 0, n_fail = 0;
  logic model_hold = 1'b1;

  always #10 clk = ~clk;

  sysdec_top u_dut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .eff_addr(eff_addr),
    .ram_sel(ram_sel), .pia_sel(pia_sel), .iot_sel(iot_sel), .rom_sel(rom_sel), .vec_sel(vec_sel));

  // {vec, rom, iot, pia[7:0], ram}
  function automatic logic [11:0] model(logic [15:0] a, logic hold);
    logic [15:0] e = hold ? (a & 16'h7FFF) : a;
    logic [11:0] s = '0;
    s[0]  = e <= 16'h01FF;
    for (int k = 0; k < 8; k++)
      s[1+k] = e >= 16'h4000 + 16'(k*1024) && e <= 16'h4003 + 16'(k*1024);
    s[9]  = e >= 16'h6200 && e <= 16'h6E07 && (e % 16'h0400) >= 16'h0200 && (e % 16'h0400) <= 16'h0207;
    s[10] = e >= 16'h7C00;
    s[10] = s[10] && e <= 16'h7FFF;
    s[11] = e >= 16'hFFC0;
    return s;
  endfunction

  task automatic probe(string req, logic [15:0] a);
    logic [11:0] got, exp;
    logic [15:0] ee;
    @(negedge clk);
    cpu_addr = a;
    #2;
    got = {vec_sel, rom_sel, iot_sel, pia_sel, ram_sel};
    exp = model(a, model_hold);
    ee  = model_hold ? (a & 16'h7FFF) : a;
    n_tests++;
    if (got !== exp || eff_addr !== ee) begin
      n_fail++;
      $display("FAIL %s addr=%h sel=%b exp=%b eff=%h exp=%h", req, a, got, exp, eff_addr, ee);
    end
  endtask

  task automatic t_reset_state();   // R6 R9
    probe("R6", 16'hFFFC); probe("R6", 16'hFFFD); probe("R6", 16'hFFC0);
    probe("R9", 16'h8100); probe("R6", 16'hC000);
  endtask

  task automatic t_release();        // R7
    @(negedge clk); rst_n = 1'b1;
    probe("R7", 16'hFFFC);            // one rising edge seen: still held
    model_hold = 1'b0;
    probe("R7", 16'hFFFC);            // second edge: released
    probe("R7", 16'hFFFD);
  endtask

  task automatic t_ram();  probe("R1", 16'h0000); probe("R1", 16'h01FF); probe("R1", 16'h0200); endtask
  task automatic t_rom();  probe("R2", 16'h7BFF); probe("R2", 16'h7C00); probe("R2", 16'h7FFF); probe("R2", 16'h8000); endtask
  task automatic t_vec();  probe("R3", 16'hFFBF); probe("R3", 16'hFFC0); probe("R3", 16'hFFFF); endtask
  task automatic t_pia();
    for (int k = 0; k < 8; k++) begin
      probe("R4", 16'h4000 + 16'(k*1024)); probe("R4", 16'h4003 + 16'(k*1024));
      probe("R4", 16'h4004 + 16'(k*1024)); probe("R4", 16'h3FFF + 16'(k*1024));
    end
  endtask
  task automatic t_iot();
    for (int k = 0; k < 4; k++) begin
      probe("R5", 16'h6200 + 16'(k*1024)); probe("R5", 16'h6207 + 16'(k*1024));
      probe("R5", 16'h61FF + 16'(k*1024)); probe("R5", 16'h6208 + 16'(k*1024));
    end
  endtask
  task automatic t_unmapped();
    probe("R8", 16'h3FFF); probe("R8", 16'h6000); probe("R8", 16'h6E08);
    probe("R8", 16'hA000); probe("R8", 16'hE200);
  endtask
  task automatic t_reassert();       // R6: async apply
    @(negedge clk); cpu_addr = 16'hFFFC; #3; rst_n = 1'b0; model_hold = 1'b1; #1;
    n_tests++;
    if (eff_addr !== 16'h7FFC || rom_sel !== 1'b1) begin
      n_fail++;
      $display("FAIL R6 async eff=%h rom=%b exp=7ffc 1", eff_addr, rom_sel);
    end
    probe("R6", 16'hFFFE);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_release();
        t_ram(); t_rom(); t_vec(); t_pia(); t_iot(); t_unmapped();
        t_reassert();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule